// File: doc/BRIEF.md
# Posted Store Buffer with First-Write and Streaming Drain Timing

This block sits between a processor's store path and a memory port. It takes byte, halfword and word stores, places each in one of four slots together with a byte-lane mask, and lets the processor continue at once. The processor is held back only when every slot is occupied. Stored entries leave for memory strictly in arrival order.

The memory side follows a fixed timing model. A store that finds the buffer empty needs a longer first access before it completes. Stores that are already queued behind a completing one then stream out at a shorter fixed interval. Each completion is shown by a one-cycle pulse, and the entry retires in that same cycle. Store data is placed on the byte lanes it addresses, and narrow values are copied to every lane, so that the memory side only has to honour the mask. An empty flag lets a read path wait until every posted store has reached memory.

Top module: `wbuf_post`

## Requirements
- R1: The buffer holds four stores. Four stores accepted while nothing completes raise `wr_stall`, and `wr_stall` stays high while all four slots are full and no completion happens in that cycle.
- R2: `wr_stall` is low whenever fewer than four slots are full, and also when all four are full but `mem_done` is high. In that second case a store offered in the same cycle is accepted into the slot being freed.
- R3: A store accepted at a clock edge while the buffer is empty produces `mem_done` in the eighth cycle after that edge.
- R4: When `mem_done` retires an entry and at least one entry remains (counting a store accepted in the same cycle), the next `mem_done` comes in the sixth cycle after that edge.
- R5: Entries reach the memory side in acceptance order. `mem_addr`, `mem_data` and `mem_mask` always show the oldest entry still held.
- R6: `wr_size` uses 0 for a byte, 1 for a halfword, and 2 or 3 for a word. The mask is 4'b0001 shifted left by `wr_addr[1:0]` for a byte, 4'b0011 for a halfword when `wr_addr[1]` is 0 and 4'b1100 when it is 1, and 4'b1111 for a word. Bit n of the mask covers data bits 8n+7..8n.
- R7: `mem_data` is `wr_data[7:0]` copied to all four lanes for a byte, `wr_data[15:0]` copied to both halves for a halfword, and `wr_data` unchanged for a word.
- R8: `buf_empty` is high exactly when no entry is held, and `mem_valid` is its inverse.
- R9: After reset the buffer is empty, `wr_stall`, `mem_valid` and `mem_done` are low.
- R10: A store offered while `wr_stall` is high is ignored and leaves no entry. `mem_addr` is the word address `wr_addr[31:2]` of the store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Store offered this cycle |
| wr_addr | input | 32 | Byte address of the store |
| wr_size | input | 2 | Store size code (see R6) |
| wr_data | input | 32 | Store data, narrow values in the low bits |
| wr_stall | output | 1 | Store cannot be taken this cycle |
| buf_empty | output | 1 | No posted store pending |
| mem_valid | output | 1 | Oldest entry presented to memory |
| mem_addr | output | 30 | Word address of the oldest entry |
| mem_data | output | 32 | Lane-placed data of the oldest entry |
| mem_mask | output | 4 | Byte-lane mask of the oldest entry |
| mem_done | output | 1 | Oldest entry completes and retires this cycle |

## Verification
The hardest situation to reach is a full buffer whose oldest entry completes in the same cycle that a new store is offered. Only then does the slot freed by the retire get refilled at once, and the following completion has to use the streaming interval. The stimulus reaches it with long runs of continuous store requests that fill all four slots and keep pressure on them. While the stall is high, the bench presents deliberately wrong store data, so an accepted stall-cycle store would show up in the drained sequence. A sweep over all size codes and low address bits, with isolated stores and random gaps, covers the lane placement and both first-access and streaming timing.

// File: rtl/wbuf_pkg.sv
`timescale 1ns/1ps
package wbuf_pkg;

    localparam int LANES   = 4;
    localparam int WORD_W  = 8 * LANES;
    localparam int WADDR_W = 30;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_WORD2 = 2'd3
    } wsize_e;

    typedef struct packed {
        logic [WADDR_W-1:0] waddr;
        logic [WORD_W-1:0]  data;
        logic [LANES-1:0]   mask;
    } entry_t;

endpackage

// File: rtl/wbuf_lane.sv
`timescale 1ns/1ps
module wbuf_lane
    import wbuf_pkg::*;
(
    input  logic [1:0]        offset,
    input  logic [1:0]        size,
    input  logic [WORD_W-1:0] data_in,
    output logic [LANES-1:0]  mask,
    output logic [WORD_W-1:0] data_out
);

    wsize_e sz;

    always_comb begin
        sz       = wsize_e'(size);
        mask     = '0;
        data_out = '0;
        for (int ln = 0; ln < LANES; ln++) begin
            unique case (sz)
                SZ_BYTE: begin
                    mask[ln]           = (offset == 2'(ln));
                    data_out[8*ln +: 8] = data_in[7:0];
                end
                SZ_HALF: begin
                    mask[ln]           = (offset[1] == ln[1]);
                    data_out[8*ln +: 8] = data_in[8*(ln % 2) +: 8];
                end
                default: begin
                    mask[ln]           = 1'b1;
                    data_out[8*ln +: 8] = data_in[8*ln +: 8];
                end
            endcase
        end
    end

endmodule

// File: rtl/wbuf_fifo.sv
`timescale 1ns/1ps
module wbuf_fifo
    import wbuf_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   push,
    input  entry_t push_entry,
    input  logic   pop,
    output entry_t head,
    output logic   empty,
    output logic   full,
    output logic   multi
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        entry_t [DEPTH-1:0] slot;
        logic [PW-1:0]      wp;
        logic [PW-1:0]      rp;
        logic [CW-1:0]      cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.slot[st_q.wp] = push_entry;
            st_d.wp            = step(st_q.wp);
        end
        if (pop) begin
            st_d.rp = step(st_q.rp);
        end
        unique case ({push, pop})
            2'b10:   st_d.cnt = st_q.cnt + CW'(1);
            2'b01:   st_d.cnt = st_q.cnt - CW'(1);
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign head  = st_q.slot[st_q.rp];
    assign empty = (st_q.cnt == '0);
    assign full  = (st_q.cnt == CW'(DEPTH));
    assign multi = (st_q.cnt > CW'(1));

endmodule

// File: rtl/wbuf_timer.sv
`timescale 1ns/1ps
module wbuf_timer #(
    parameter int FIRST_LAT = 8,
    parameter int NEXT_LAT  = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_cold,
    input  logic busy,
    input  logic more_after,
    output logic done
);

    localparam int LMAX = (FIRST_LAT > NEXT_LAT) ? FIRST_LAT : NEXT_LAT;
    localparam int TW   = $clog2(LMAX + 1);

    typedef struct packed {
        logic [TW-1:0] left;
    } tmr_st_t;

    tmr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        done = busy && (st_q.left == '0);
        if (start_cold) begin
            st_d.left = TW'(FIRST_LAT - 1);
        end else if (done) begin
            st_d.left = more_after ? TW'(NEXT_LAT - 1) : '0;
        end else if (st_q.left != '0) begin
            st_d.left = st_q.left - TW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/wbuf_post.sv
`timescale 1ns/1ps
module wbuf_post
    import wbuf_pkg::*;
#(
    parameter int DEPTH     = 4,
    parameter int FIRST_LAT = 8,
    parameter int NEXT_LAT  = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_valid,
    input  logic [31:0]         wr_addr,
    input  logic [1:0]          wr_size,
    input  logic [WORD_W-1:0]   wr_data,
    output logic                wr_stall,
    output logic                buf_empty,
    output logic                mem_valid,
    output logic [WADDR_W-1:0]  mem_addr,
    output logic [WORD_W-1:0]   mem_data,
    output logic [LANES-1:0]    mem_mask,
    output logic                mem_done
);

    logic             f_empty, f_full, f_multi;
    logic             accept, retire;
    entry_t           new_entry, head;
    logic [LANES-1:0] lane_mask;
    logic [WORD_W-1:0] lane_data;

    wbuf_lane u_lane (
        .offset   (wr_addr[1:0]),
        .size     (wr_size),
        .data_in  (wr_data),
        .mask     (lane_mask),
        .data_out (lane_data)
    );

    always_comb begin
        new_entry.waddr = wr_addr[31:2];
        new_entry.data  = lane_data;
        new_entry.mask  = lane_mask;
    end

    assign wr_stall = f_full && !retire;
    assign accept   = wr_valid && !wr_stall;

    wbuf_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (accept),
        .push_entry (new_entry),
        .pop        (retire),
        .head       (head),
        .empty      (f_empty),
        .full       (f_full),
        .multi      (f_multi)
    );

    wbuf_timer #(.FIRST_LAT(FIRST_LAT), .NEXT_LAT(NEXT_LAT)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_cold (accept && f_empty),
        .busy       (!f_empty),
        .more_after (f_multi || accept),
        .done       (retire)
    );

    assign buf_empty = f_empty;
    assign mem_valid = !f_empty;
    assign mem_addr  = head.waddr;
    assign mem_data  = head.data;
    assign mem_mask  = head.mask;
    assign mem_done  = retire;

endmodule

// File: rtl/wbuf_post_chk.sv
`timescale 1ns/1ps
module wbuf_post_chk #(
    parameter int DEPTH     = 4,
    parameter int FIRST_LAT = 8,
    parameter int NEXT_LAT  = 6
) (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_valid,
    input logic       wr_stall,
    input logic       buf_empty,
    input logic       mem_valid,
    input logic [3:0] mem_mask,
    input logic       mem_done
);

    localparam int OW   = $clog2(DEPTH + 1) + 1;
    localparam int LMAX = (FIRST_LAT > NEXT_LAT) ? FIRST_LAT : NEXT_LAT;
    localparam int KW   = $clog2(LMAX + 2) + 1;

    logic [OW-1:0] occ_q, occ_d;
    logic [KW-1:0] tick_q;
    logic          cold_q;
    logic          acc;

    assign acc   = wr_valid && !wr_stall;
    assign occ_d = occ_q + OW'(acc) - OW'(mem_done);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ_q  <= '0;
            tick_q <= '0;
            cold_q <= 1'b0;
        end else begin
            occ_q <= occ_d;
            if (acc && occ_q == '0) begin
                tick_q <= KW'(1);
                cold_q <= 1'b1;
            end else if (mem_done && occ_d != '0) begin
                tick_q <= KW'(1);
                cold_q <= 1'b0;
            end else if (tick_q <= KW'(LMAX)) begin
                tick_q <= tick_q + KW'(1);
            end
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        occ_q <= OW'(DEPTH)); // R1
    AST_STALL_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stall |-> (occ_q == OW'(DEPTH) && !mem_done)); // R2
    AST_NO_STALL_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        (occ_q < OW'(DEPTH)) |-> !wr_stall); // R2
    AST_COLD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_done && cold_q) |-> (tick_q == KW'(FIRST_LAT))); // R3
    AST_STREAM_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_done && !cold_q) |-> (tick_q == KW'(NEXT_LAT))); // R4
    AST_MASK_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> ($countones(mem_mask) == 1 || mem_mask == 4'b0011 ||
                       mem_mask == 4'b1100 || mem_mask == 4'b1111)); // R6
    AST_EMPTY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        buf_empty == (occ_q == '0)); // R8
    AST_VALID_INV: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid == !buf_empty); // R8
    AST_DONE_NEEDS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_done |-> mem_valid); // R5

endmodule

bind wbuf_post wbuf_post_chk #(
    .DEPTH(DEPTH), .FIRST_LAT(FIRST_LAT), .NEXT_LAT(NEXT_LAT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_valid  (wr_valid),
    .wr_stall  (wr_stall),
    .buf_empty (buf_empty),
    .mem_valid (mem_valid),
    .mem_mask  (mem_mask),
    .mem_done  (mem_done)
);

// File: tb/wbuf_post_test.sv
`timescale 1ns/1ps
module wbuf_post_test;

    localparam int FIRST = 8;
    localparam int NEXT  = 6;
    localparam int SLOTS = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [31:0] wr_addr = '0;
    logic [1:0]  wr_size = '0;
    logic [31:0] wr_data = '0;
    logic        wr_stall, buf_empty, mem_valid, mem_done;
    logic [29:0] mem_addr;
    logic [31:0] mem_data;
    logic [3:0]  mem_mask;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    wbuf_post uut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_size(wr_size), .wr_data(wr_data), .wr_stall(wr_stall),
        .buf_empty(buf_empty), .mem_valid(mem_valid), .mem_addr(mem_addr),
        .mem_data(mem_data), .mem_mask(mem_mask), .mem_done(mem_done)
    );

    logic [29:0] qa [256];
    logic [31:0] qd [256];
    logic [3:0]  qm [256];
    int qh = 0, qt = 0, occ = 0, tmr = 0, k = 0;
    bit cold = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] mask_of(input logic [1:0] sz, input logic [1:0] off);
        if (sz == 2'd0) return 4'b0001 << off;
        if (sz == 2'd1) return off[1] ? 4'b1100 : 4'b0011;
        return 4'b1111;
    endfunction

    function automatic logic [31:0] data_of(input logic [1:0] sz, input logic [31:0] d);
        if (sz == 2'd0) return {24'b0, d[7:0]} * 32'h0101_0101;
        if (sz == 2'd1) return {16'b0, d[15:0]} * 32'h0001_0001;
        return d;
    endfunction

    task automatic step(input bit want);
        bit exp_done, exp_stall, acc;
        int nocc;
        @(negedge clk);
        exp_done  = (occ > 0) && (tmr == 1);
        exp_stall = (occ == SLOTS) && !exp_done;
        chk(wr_stall == exp_stall, (occ == SLOTS) ? "R1 stall" : "R2 stall",
            32'(wr_stall), 32'(exp_stall));
        chk(buf_empty == (occ == 0), "R8 empty", 32'(buf_empty), 32'(occ == 0));
        chk(mem_valid == (occ > 0), "R8 valid", 32'(mem_valid), 32'(occ > 0));
        chk(mem_done == exp_done, cold ? "R3 done" : "R4 done",
            32'(mem_done), 32'(exp_done));
        if (occ > 0) begin
            chk(mem_addr == qa[qh], "R10 addr", 32'(mem_addr), 32'(qa[qh]));
            chk(mem_mask == qm[qh], "R6 mask", 32'(mem_mask), 32'(qm[qh]));
            chk(mem_data == qd[qh], "R5/R7 data", mem_data, qd[qh]);
        end
        acc = want && !exp_stall;
        wr_valid = want;
        if (acc) begin
            wr_size = 2'(k % 4);
            wr_addr = (32'(k) * 32'h0001_0340) | 32'((k / 4) % 4);
            wr_data = 32'(k) * 32'h9E37_79B1 + 32'h1234;
            qa[qt % 256] = wr_addr[31:2];
            qm[qt % 256] = mask_of(wr_size, wr_addr[1:0]);
            qd[qt % 256] = data_of(wr_size, wr_data);
            qt++;
            k++;
        end else begin
            wr_size = 2'(k % 3);
            wr_addr = 32'hDEAD_BEE0 ^ 32'(k);
            wr_data = 32'hBAD0_0BAD ^ 32'(k);
        end
        if (exp_done) qh = (qh + 1) % 256;
        nocc = occ + (acc ? 1 : 0) - (exp_done ? 1 : 0);
        if (acc && occ == 0) begin
            tmr = FIRST; cold = 1'b1;
        end else if (exp_done) begin
            if (nocc > 0) begin tmr = NEXT; cold = 1'b0; end else tmr = 0;
        end else if (tmr > 1) begin
            tmr--;
        end
        occ = nocc;
        qt = qt % 256;
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(buf_empty == 1'b1 && !wr_stall && !mem_valid && !mem_done, "R9 reset",
            {28'b0, buf_empty, wr_stall, mem_valid, mem_done}, 32'h8);
        rst_n = 1'b1;
        // isolated stores: cold latency, every size and offset
        for (int c = 0; c < 400; c++) step((occ == 0) && (c % 12 == 0));
        // bursts of continuous requests: fill, stall, refill on retire
        for (int c = 0; c < 2400; c++) step(((c / 60) % 2) == 0);
        // random gaps
        for (int c = 0; c < 4000; c++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[1:0] == 2'b00 || (c % 500) < 80);
        end
        for (int c = 0; c < 60; c++) step(1'b0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule